// File: doc/BRIEF.md
# Bus Response Timeout Monitor

This block times every bus cycle that the processor starts and counts, in system clocks, how long the responder takes to end it with a data/size acknowledge or an autovector response. If neither arrives within a limit chosen by a 2-bit code, the monitor emits a one-clock bus-error pulse so the processor can abort the transfer. When a word is moved to an 8-bit port as two byte accesses, the count runs across both halves and is only cleared when the second half is acknowledged.

Monitoring can be switched off entirely, suspended while a debug freeze is active with freeze-disable set, and is always suspended during low-power stop. In any of these conditions a cycle being timed is dropped without an error. The block has no data path; all pins are plain control and status signals with no valid/ready handshake and no back-pressure.

Top module: `bus_resp_monitor`

## Requirements
- R1: While `rst` is high on a clock edge, `bus_err` and `busy` are 0 after that edge.
- R2: The limit is latched when a cycle starts from `tmo_sel`: code 3 gives 8 clocks, code 2 gives 16, code 1 gives 32, code 0 gives 64.
- R3: With no acknowledge, `bus_err` goes high after the L-th clock edge following the start edge (L the latched limit), stays high for exactly one clock, and `busy` drops on the same edge.
- R4: `dsack` or `avec` high on an edge while `busy` ends the cycle (`busy` low next) with no error; an acknowledge on the same edge as expiry wins.
- R5: When `split_word` is high at start, the first acknowledge keeps `busy` high and does not clear the count; the second ends the cycle, and expiry still occurs L clocks after the start.
- R6: With `mon_en` low, `cyc_start` is ignored, and dropping `mon_en` during a cycle drops it with no error.
- R7: With `freeze` and `frz_disable` both high the monitor is idle (no start, cycle dropped, no error); `freeze` alone has no effect.
- R8: With `lp_stop` high the monitor is idle in the same way.
- R9: A `cyc_start` during a timed cycle restarts the count from zero with a newly latched limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | Strobe marking the first clock of a bus cycle |
| dsack | input | 1 | Data/size acknowledge from the responder |
| avec | input | 1 | Autovector response from the responder |
| split_word | input | 1 | Cycle is a word moved as two byte accesses (sampled with cyc_start) |
| tmo_sel | input | 2 | Timeout code (sampled with cyc_start) |
| mon_en | input | 1 | Monitor enable |
| freeze | input | 1 | Debug freeze active |
| frz_disable | input | 1 | Suspend the monitor while frozen |
| lp_stop | input | 1 | Low-power stop mode active |
| bus_err | output | 1 | One-clock bus-error pulse on timeout |
| busy | output | 1 | A cycle is being timed |

## Verification
The bench builds the monitor with its default parameters (base limit 8, 2-bit code), so all four limits up to 64 clocks are reached in short directed runs and each expiry edge is checked one clock before, at and after. With these values the split-word case, the acknowledge racing the expiry edge, and restarts and suspensions in the middle of a count are all exercised on exact cycle boundaries.

// File: rtl/bmon_pkg.sv
package bmon_pkg;
  localparam int unsigned CODE_W    = 2;
  localparam int unsigned NUM_CODES = 1 << CODE_W;
endpackage

// File: rtl/bmon_limit_dec.sv
module bmon_limit_dec
  import bmon_pkg::*;
#(
  parameter int unsigned BASE_LIMIT = 8,
  parameter int unsigned CNT_W      = 7
) (
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  limit
);
  logic [CNT_W-1:0] tbl [NUM_CODES];

  // Highest code gives the shortest limit; each step down doubles it.
  for (genvar i = 0; i < NUM_CODES; i++) begin : g_tbl
    assign tbl[i] = CNT_W'(BASE_LIMIT << (NUM_CODES - 1 - i));
  end

  assign limit = tbl[code];
endmodule

// File: rtl/bmon_timer.sv
module bmon_timer #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             at_last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (run)     cnt_q <= cnt_q + 1'b1;
  end

  assign at_last = (cnt_q == limit - 1'b1);

  // R2: a running count never reaches the latched limit
  a_r2_below_limit: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q < limit));
endmodule

// File: rtl/bus_resp_monitor.sv
module bus_resp_monitor
  import bmon_pkg::*;
#(
  parameter int unsigned BASE_LIMIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_start,
  input  logic              dsack,
  input  logic              avec,
  input  logic              split_word,
  input  logic [CODE_W-1:0] tmo_sel,
  input  logic              mon_en,
  input  logic              freeze,
  input  logic              frz_disable,
  input  logic              lp_stop,
  output logic              bus_err,
  output logic              busy
);
  localparam int unsigned MAX_LIMIT = BASE_LIMIT << (NUM_CODES - 1);
  localparam int unsigned CNT_W     = $clog2(MAX_LIMIT + 1);

  logic             active, ack, final_ack, expire, tmr_clear, at_last;
  logic             busy_q, half2_q, err_q;
  logic [CNT_W-1:0] dec_limit, lim_q;

  bmon_limit_dec #(.BASE_LIMIT(BASE_LIMIT), .CNT_W(CNT_W)) u_dec (
    .code  (tmo_sel),
    .limit (dec_limit)
  );

  assign active    = mon_en && !(freeze && frz_disable) && !lp_stop;
  assign ack       = dsack || avec;
  assign final_ack = busy_q && ack && !half2_q;
  assign expire    = busy_q && at_last && !final_ack;
  assign tmr_clear = !active || cyc_start || final_ack || expire;

  bmon_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .clear   (tmr_clear),
    .run     (busy_q),
    .limit   (lim_q),
    .at_last (at_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      half2_q <= 1'b0;
      err_q   <= 1'b0;
      lim_q   <= '0;
    end else begin
      err_q <= 1'b0;
      if (!active) begin
        busy_q  <= 1'b0;
        half2_q <= 1'b0;
      end else if (cyc_start) begin
        busy_q  <= 1'b1;
        half2_q <= split_word;
        lim_q   <= dec_limit;
      end else if (final_ack) begin
        busy_q  <= 1'b0;
      end else if (expire) begin
        busy_q  <= 1'b0;
        half2_q <= 1'b0;
        err_q   <= 1'b1;
      end else if (busy_q && ack) begin
        half2_q <= 1'b0;
      end
    end
  end

  assign bus_err = err_q;
  assign busy    = busy_q;

  // R1: reset leaves both outputs low
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!busy && !bus_err));
  // R3: error is a single clock and never overlaps a timed cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    bus_err |=> !bus_err);
  a_r3_err_not_busy: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> !busy);
  // R4: final acknowledge ends the cycle cleanly
  a_r4_ack_clean: assert property (@(posedge clk) disable iff (rst)
    (active && !cyc_start && final_ack) |=> (!busy && !bus_err));
  // R5: first half acknowledge before expiry keeps the cycle open
  a_r5_first_half: assert property (@(posedge clk) disable iff (rst)
    (active && !cyc_start && busy && ack && half2_q && !at_last) |=> busy);
  // R6: disabled monitor stays idle
  a_r6_disabled_idle: assert property (@(posedge clk) disable iff (rst)
    !mon_en |=> (!busy && !bus_err));
  // R7: frozen with freeze-disable stays idle
  a_r7_frozen_idle: assert property (@(posedge clk) disable iff (rst)
    (freeze && frz_disable) |=> (!busy && !bus_err));
  // R8: low-power stop stays idle
  a_r8_stop_idle: assert property (@(posedge clk) disable iff (rst)
    lp_stop |=> (!busy && !bus_err));
  // R9: a start while active always opens a cycle
  a_r9_start_busy: assert property (@(posedge clk) disable iff (rst)
    (active && cyc_start) |=> (busy && !bus_err));
endmodule

// File: tb/bus_resp_monitor_tb.sv
module bus_resp_monitor_tb;
  logic       clk = 1'b0;
  logic       rst, cyc_start, dsack, avec, split_word;
  logic [1:0] tmo_sel;
  logic       mon_en, freeze, frz_disable, lp_stop;
  logic       bus_err, busy;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  bus_resp_monitor u_dut (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .dsack(dsack), .avec(avec),
    .split_word(split_word), .tmo_sel(tmo_sel), .mon_en(mon_en),
    .freeze(freeze), .frz_disable(frz_disable), .lp_stop(lp_stop),
    .bus_err(bus_err), .busy(busy)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int lim_of(input logic [1:0] c);
    return 8 << (3 - c);
  endfunction

  // Leaves the bench at the negedge just after the start edge.
  task automatic start(input logic [1:0] sel, input logic sp);
    cyc_start = 1'b1; tmo_sel = sel; split_word = sp;
    tick(1);
    cyc_start = 1'b0; split_word = 1'b0;
  endtask

  task automatic ack_pulse(input logic use_avec);
    if (use_avec) avec = 1'b1; else dsack = 1'b1;
    tick(1);
    avec = 1'b0; dsack = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1; tick(2);
    chk("R1 busy", busy, 1'b0);
    chk("R1 bus_err", bus_err, 1'b0);
    rst = 1'b0; tick(1);
  endtask

  task automatic t_limits;
    for (int c = 0; c < 4; c++) begin
      start(2'(c), 1'b0);
      tick(lim_of(2'(c)) - 1);
      chk("R2 before limit err", bus_err, 1'b0);
      chk("R2 before limit busy", busy, 1'b1);
      tick(1);
      chk("R2/R3 at limit err", bus_err, 1'b1);
      chk("R3 busy drops", busy, 1'b0);
      tick(1);
      chk("R3 one-clock pulse", bus_err, 1'b0);
      tick(2);
    end
  endtask

  task automatic t_ack;
    start(2'd0, 1'b0); tick(5);
    ack_pulse(1'b0);
    chk("R4 dsack ends busy", busy, 1'b0);
    tick(70);
    chk("R4 no error after dsack", bus_err, 1'b0);
    start(2'd3, 1'b0); tick(7);
    ack_pulse(1'b1);
    chk("R4 avec on expiry edge wins err", bus_err, 1'b0);
    chk("R4 avec on expiry edge busy", busy, 1'b0);
    tick(3);
  endtask

  task automatic t_split;
    start(2'd3, 1'b1); tick(3);
    ack_pulse(1'b0);
    chk("R5 first half keeps busy", busy, 1'b1);
    tick(3);
    chk("R5 count not cleared, no err yet", bus_err, 1'b0);
    tick(1);
    chk("R5 expiry counts from start", bus_err, 1'b1);
    tick(2);
    start(2'd2, 1'b1); tick(4);
    ack_pulse(1'b0); tick(2);
    ack_pulse(1'b1);
    chk("R5 second half ends", busy, 1'b0);
    tick(20);
    chk("R5 no err after both halves", bus_err, 1'b0);
  endtask

  task automatic t_disable;
    mon_en = 1'b0;
    start(2'd3, 1'b0);
    chk("R6 start ignored", busy, 1'b0);
    tick(10);
    chk("R6 no error when disabled", bus_err, 1'b0);
    mon_en = 1'b1;
    start(2'd3, 1'b0); tick(3);
    mon_en = 1'b0; tick(1);
    chk("R6 mid-cycle drop", busy, 1'b0);
    tick(10);
    chk("R6 no error after drop", bus_err, 1'b0);
    mon_en = 1'b1; tick(1);
  endtask

  task automatic t_freeze;
    freeze = 1'b1; frz_disable = 1'b0;
    start(2'd3, 1'b0); tick(7);
    chk("R7 freeze alone no effect", bus_err, 1'b0);
    tick(1);
    chk("R7 freeze alone still expires", bus_err, 1'b1);
    tick(2);
    freeze = 1'b0;
    start(2'd3, 1'b0); tick(2);
    freeze = 1'b1; frz_disable = 1'b1; tick(1);
    chk("R7 frozen drops cycle", busy, 1'b0);
    start(2'd3, 1'b0);
    chk("R7 start ignored while frozen", busy, 1'b0);
    tick(12);
    chk("R7 no error while frozen", bus_err, 1'b0);
    freeze = 1'b0; frz_disable = 1'b0; tick(1);
  endtask

  task automatic t_stop;
    start(2'd3, 1'b0); tick(2);
    lp_stop = 1'b1; tick(1);
    chk("R8 stop drops cycle", busy, 1'b0);
    start(2'd3, 1'b0);
    chk("R8 start ignored in stop", busy, 1'b0);
    tick(12);
    chk("R8 no error in stop", bus_err, 1'b0);
    lp_stop = 1'b0; tick(1);
  endtask

  task automatic t_restart;
    start(2'd3, 1'b0); tick(5);
    start(2'd2, 1'b0);
    tick(15);
    chk("R9 restart: no err before new limit", bus_err, 1'b0);
    chk("R9 restart: still busy", busy, 1'b1);
    tick(1);
    chk("R9 restart: err at new limit", bus_err, 1'b1);
    tick(2);
  endtask

  initial begin
    rst = 1'b1; cyc_start = 0; dsack = 0; avec = 0; split_word = 0;
    tmo_sel = 2'd0; mon_en = 1; freeze = 0; frz_disable = 0; lp_stop = 0;
    tick(1);
    t_reset;
    t_limits;
    t_ack;
    t_split;
    t_disable;
    t_freeze;
    t_stop;
    t_restart;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule